// File: doc/BRIEF.md
# Partial-Word Load/Store Merge Unit

This block performs the byte shifting and merging behind the four unaligned word instructions of a big-endian 32-bit load/store architecture: load-left, load-right, store-left and store-right. It receives the instruction word, the low bits of the effective address, the register operand and the aligned memory word at that address. It decodes the instruction and produces three results. The first is the merged register value for loads. The second is a lane-aligned write-data word for stores. The third is a byte-enable mask that tells the memory which lanes to overwrite.

Byte offset 0 is the most significant byte of the aligned word. A left variant works from the addressed byte towards the low end of the word. A right variant works from the start of the word up to the addressed byte. Any other opcode falls into a plain mode: the memory word goes straight to the load result, and a store writes the whole register with all four enables set.

The results are registered behind a two-state output controller with the states `ST_EMPTY` and `ST_LOADED`. The transition `T_CAPTURE` goes to `ST_LOADED` on any cycle with `in_valid` high, from either state. The transition `T_DRAIN` goes to `ST_EMPTY` on any cycle with `in_valid` low. The output `out_valid` is high exactly in `ST_LOADED`.

Top module: `pwx_merge_top`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `load_data`, `store_data` and `store_be` are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: The opcode in instruction bits 31:26 selects the mode: 0x22 load-left, 0x26 load-right, 0x2A store-left, 0x2E store-right, and any other value the plain mode. Bits 25:0 have no effect.
- R4: Memory is big-endian: offset 0 is bits 31:24 of the word and offset 3 is bits 7:0.
- R5: Load-left at offset o fills the top 4-o register bytes with memory bytes o..3 and keeps the low o register bytes. With register 0xAABBCCDD and memory 0x01020304, offsets 0..3 give 0x01020304, 0x020304DD, 0x0304CCDD and 0x04BBCCDD.
- R6: Load-right at offset o fills the low o+1 register bytes with memory bytes 0..o and keeps the upper bytes. With the same operands, offsets 0..3 give 0xAABBCC01, 0xAABB0102, 0xAA010203 and 0x01020304.
- R7: Store-left at offset o enables memory offsets o..3. `store_be` bit 3 is offset 0, so the mask is 1111, 0111, 0011 or 0001. Each enabled lane carries register byte (offset - o), counting register bytes from the most significant.
- R8: Store-right at offset o enables memory offsets 0..o, giving the mask 1000, 1100, 1110 or 1111. Each enabled lane carries register byte (offset + 3 - o).
- R9: In plain mode, `load_data` equals the memory word, `store_be` is 1111 and `store_data` equals the register value.
- R10: When a store is applied through `store_be`, memory bytes whose enable is clear keep their old value.
- R11: In any cycle after a cycle with `in_valid` low, `load_data`, `store_data` and `store_be` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| instr | input | INSTR_W (32) | Instruction word; opcode in the top six bits |
| addr_lo | input | OFF_W (2) | Byte offset of the effective address within the word |
| reg_val | input | DW (32) | Destination register value for loads, source register value for stores |
| mem_word | input | DW (32) | Aligned memory word at the effective address |
| out_valid | output | 1 | Registered results are valid |
| load_data | output | DW (32) | Merged register value |
| store_data | output | DW (32) | Lane-aligned write data; only lanes enabled in `store_be` are meaningful |
| store_be | output | BYTES (4) | Byte enables; bit BYTES-1 is offset 0 |

## Verification
The bench builds the unit with its default parameters, four byte lanes and a 32-bit instruction. This puts every offset of every mode in reach, and with it every boundary: a left variant at offset 3 moves a single byte, and a right variant at offset 3 moves the full word. The published operand patterns are applied at all four offsets. Randomly mixed instructions follow, with random register bits and idle cycles between them, so that each output mode and the hold behaviour are compared against a shift-and-mask model on every clock.

// File: rtl/pwx_pkg.sv
package pwx_pkg;

    // primary opcodes of the partial-word instructions
    localparam logic [5:0] OPC_LOAD_LEFT   = 6'h22;
    localparam logic [5:0] OPC_LOAD_RIGHT  = 6'h26;
    localparam logic [5:0] OPC_STORE_LEFT  = 6'h2A;
    localparam logic [5:0] OPC_STORE_RIGHT = 6'h2E;

    typedef enum logic [2:0] {
        K_PLAIN = 3'd0,
        K_LL    = 3'd1,
        K_LR    = 3'd2,
        K_SL    = 3'd3,
        K_SR    = 3'd4
    } pw_kind_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } pw_state_e;

endpackage

// File: rtl/pwx_decode.sv
module pwx_decode
    import pwx_pkg::*;
#(
    parameter int INSTR_W = 32,
    localparam int OPC_LSB = INSTR_W - 6
) (
    input  logic [INSTR_W-1:0] instr,
    output pw_kind_e           kind
);

    logic [5:0] opc;
    assign opc = instr[OPC_LSB +: 6];

    always_comb begin
        unique case (opc)
            OPC_LOAD_LEFT:   kind = K_LL;
            OPC_LOAD_RIGHT:  kind = K_LR;
            OPC_STORE_LEFT:  kind = K_SL;
            OPC_STORE_RIGHT: kind = K_SR;
            default:         kind = K_PLAIN;
        endcase
    end

endmodule

// File: rtl/pwx_load_merge.sv
module pwx_load_merge
    import pwx_pkg::*;
#(
    parameter int BYTES = 4,
    localparam int OFF_W = $clog2(BYTES),
    localparam int DW = 8 * BYTES
) (
    input  pw_kind_e          kind,
    input  logic [OFF_W-1:0]  off,
    input  logic [DW-1:0]     reg_val,
    input  logic [DW-1:0]     mem_word,
    output logic [DW-1:0]     merged
);

    // byte arrays indexed by big-endian position (0 = most significant)
    logic [7:0] mem_b [BYTES];
    logic [7:0] reg_b [BYTES];

    for (genvar k = 0; k < BYTES; k++) begin : g_unpack
        assign mem_b[k] = mem_word[(BYTES-1-k)*8 +: 8];
        assign reg_b[k] = reg_val[(BYTES-1-k)*8 +: 8];
    end

    for (genvar j = 0; j < BYTES; j++) begin : g_pos
        logic             take;
        logic [OFF_W-1:0] src_idx;

        always_comb begin
            int src;
            int offi;
            offi = int'(off);
            take = 1'b0;
            src  = j;
            unique case (kind)
                K_LL: begin
                    take = (j < BYTES - offi);
                    src  = offi + j;
                end
                K_LR: begin
                    take = (j >= BYTES - 1 - offi);
                    src  = j - (BYTES - 1 - offi);
                end
                default: begin
                    take = (kind == K_PLAIN) || (kind == K_SL) || (kind == K_SR);
                    src  = j;
                end
            endcase
            src_idx = src[OFF_W-1:0];
        end

        assign merged[(BYTES-1-j)*8 +: 8] = take ? mem_b[src_idx] : reg_b[j];
    end

endmodule

// File: rtl/pwx_store_lane.sv
module pwx_store_lane
    import pwx_pkg::*;
#(
    parameter int BYTES = 4,
    localparam int OFF_W = $clog2(BYTES),
    localparam int DW = 8 * BYTES
) (
    input  pw_kind_e          kind,
    input  logic [OFF_W-1:0]  off,
    input  logic [DW-1:0]     reg_val,
    output logic [DW-1:0]     wdata,
    output logic [BYTES-1:0]  be
);

    logic [7:0] reg_b [BYTES];

    for (genvar k = 0; k < BYTES; k++) begin : g_unpack
        assign reg_b[k] = reg_val[(BYTES-1-k)*8 +: 8];
    end

    // p is the memory position (0 = most significant lane)
    for (genvar p = 0; p < BYTES; p++) begin : g_lane
        logic             en;
        logic [OFF_W-1:0] src_idx;

        always_comb begin
            int src;
            int offi;
            offi = int'(off);
            en   = 1'b1;
            src  = p;
            unique case (kind)
                K_SL: begin
                    en  = (p >= offi);
                    src = p - offi;
                end
                K_SR: begin
                    en  = (p <= offi);
                    src = p + BYTES - 1 - offi;
                end
                default: begin
                    en  = 1'b1;
                    src = p;
                end
            endcase
            src_idx = src[OFF_W-1:0];
        end

        assign wdata[(BYTES-1-p)*8 +: 8] = reg_b[src_idx];
        assign be[BYTES-1-p]             = en;
    end

endmodule

// File: rtl/pwx_merge_top.sv
module pwx_merge_top
    import pwx_pkg::*;
#(
    parameter int BYTES = 4,
    parameter int INSTR_W = 32,
    localparam int OFF_W = $clog2(BYTES),
    localparam int DW = 8 * BYTES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [OFF_W-1:0]   addr_lo,
    input  logic [DW-1:0]      reg_val,
    input  logic [DW-1:0]      mem_word,
    output logic               out_valid,
    output logic [DW-1:0]      load_data,
    output logic [DW-1:0]      store_data,
    output logic [BYTES-1:0]   store_be
);

    pw_kind_e         kind_d;
    pw_kind_e         kind_q;
    logic [OFF_W-1:0] off_q;
    logic [DW-1:0]    merged_d;
    logic [DW-1:0]    wdata_d;
    logic [BYTES-1:0] be_d;
    pw_state_e        state_q;
    pw_state_e        state_d;

    pwx_decode #(.INSTR_W(INSTR_W)) u_dec (
        .instr (instr),
        .kind  (kind_d)
    );

    pwx_load_merge #(.BYTES(BYTES)) u_ld (
        .kind     (kind_d),
        .off      (addr_lo),
        .reg_val  (reg_val),
        .mem_word (mem_word),
        .merged   (merged_d)
    );

    pwx_store_lane #(.BYTES(BYTES)) u_st (
        .kind    (kind_d),
        .off     (addr_lo),
        .reg_val (reg_val),
        .wdata   (wdata_d),
        .be      (be_d)
    );

    // next-state: T_CAPTURE / T_DRAIN
    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // output registers, loaded only on capture
    always_ff @(posedge clk) begin
        if (rst) begin
            load_data  <= '0;
            store_data <= '0;
            store_be   <= '0;
            kind_q     <= K_PLAIN;
            off_q      <= '0;
        end else if (in_valid) begin
            load_data  <= merged_d;
            store_data <= wdata_d;
            store_be   <= be_d;
            kind_q     <= kind_d;
            off_q      <= addr_lo;
        end
    end

    assign out_valid = (state_q == ST_LOADED);

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R11
    hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(load_data) && $stable(store_data) && $stable(store_be)));

    // R5
    ll_full_word_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind_d == K_LL && addr_lo == '0) |=> (load_data == $past(mem_word)));

    // R6
    lr_full_word_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind_d == K_LR && addr_lo == OFF_W'(BYTES-1)) |=> (load_data == $past(mem_word)));

    // R7
    sl_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && kind_q == K_SL) |-> (store_be[0] && $countones(store_be) == BYTES - int'(off_q)));

    // R8
    sr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && kind_q == K_SR) |-> (store_be[BYTES-1] && $countones(store_be) == int'(off_q) + 1));

    // R9
    plain_be_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (kind_q == K_PLAIN || kind_q == K_LL || kind_q == K_LR)) |-> (&store_be));

endmodule

// File: tb/sim_pwx_merge_top.sv
module sim_pwx_merge_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [1:0]  addr_lo = '0;
    logic [31:0] reg_val = '0;
    logic [31:0] mem_word = '0;
    logic        out_valid;
    logic [31:0] load_data;
    logic [31:0] store_data;
    logic [3:0]  store_be;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // previous-cycle stimulus for the reference model
    logic        p_valid = 1'b0;
    logic [31:0] p_ins = '0;
    logic [1:0]  p_off = '0;
    logic [31:0] p_reg = '0;
    logic [31:0] p_mem = '0;
    logic        p_hasx = 1'b0;
    logic [31:0] p_x = '0;
    logic [31:0] hold_ld = '0;
    logic [31:0] hold_sd = '0;
    logic [3:0]  hold_be = '0;

    always #10 clk = ~clk;

    pwx_merge_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .addr_lo(addr_lo), .reg_val(reg_val), .mem_word(mem_word),
        .out_valid(out_valid), .load_data(load_data),
        .store_data(store_data), .store_be(store_be)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lanes(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
        return m;
    endfunction

    function automatic logic [31:0] ref_ll(input logic [31:0] r, input logic [31:0] m, input logic [1:0] o);
        logic [63:0] low;
        logic [31:0] sh;
        low = (64'd1 << (8 * o)) - 64'd1;
        sh  = m << (8 * o);
        return sh | (r & low[31:0]);
    endfunction

    function automatic logic [31:0] ref_lr(input logic [31:0] r, input logic [31:0] m, input logic [1:0] o);
        logic [63:0] low;
        logic [31:0] sh;
        low = (64'd1 << (8 * (o + 1))) - 64'd1;
        sh  = m >> (8 * (3 - o));
        return sh | (r & ~low[31:0]);
    endfunction

    task automatic check_prev();
        logic [31:0] e, lm, nm, ed;
        logic [3:0]  ebe;
        chk(out_valid === p_valid, "R2", {31'd0, out_valid}, {31'd0, p_valid});
        if (p_valid) begin
            case (p_ins[31:26])
                6'h22: begin
                    e = ref_ll(p_reg, p_mem, p_off);
                    chk(load_data === e, "R5", load_data, e);
                    if (p_hasx) chk(load_data === p_x, "R4", load_data, p_x);
                end
                6'h26: begin
                    e = ref_lr(p_reg, p_mem, p_off);
                    chk(load_data === e, "R6", load_data, e);
                    if (p_hasx) chk(load_data === p_x, "R4", load_data, p_x);
                end
                6'h2A, 6'h2E: begin
                    if (p_ins[31:26] == 6'h2A) begin
                        ebe = 4'hF >> p_off;
                        ed  = p_reg >> (8 * p_off);
                        chk(store_be === ebe, "R7", {28'd0, store_be}, {28'd0, ebe});
                        lm = lanes(ebe);
                        chk((store_data & lm) === (ed & lm), "R7", store_data & lm, ed & lm);
                    end else begin
                        ebe = 4'(4'hF << (3 - p_off));
                        ed  = p_reg << (8 * (3 - p_off));
                        chk(store_be === ebe, "R8", {28'd0, store_be}, {28'd0, ebe});
                        lm = lanes(ebe);
                        chk((store_data & lm) === (ed & lm), "R8", store_data & lm, ed & lm);
                    end
                    nm = (p_mem & ~lanes(store_be)) | (store_data & lanes(store_be));
                    chk((nm & ~lm) === (p_mem & ~lm), "R10", nm & ~lm, p_mem & ~lm);
                    if (p_hasx) chk(nm === p_x, "R4", nm, p_x);
                end
                default: begin
                    // R3: any other opcode is plain mode
                    chk(load_data === p_mem, "R9 (R3 decode)", load_data, p_mem);
                    chk(store_be === 4'hF, "R9", {28'd0, store_be}, 32'hF);
                    chk(store_data === p_reg, "R9", store_data, p_reg);
                end
            endcase
            hold_ld = load_data;
            hold_sd = store_data;
            hold_be = store_be;
        end else begin
            chk(load_data === hold_ld && store_data === hold_sd && store_be === hold_be,
                "R11", load_data, hold_ld);
        end
    endtask

    task automatic step(input logic v, input logic [5:0] op, input logic [1:0] o,
                        input logic [31:0] r, input logic [31:0] m,
                        input logic hx, input logic [31:0] x);
        logic [31:0] ins;
        @(negedge clk);
        check_prev();
        ins = {op, 26'($urandom)};
        in_valid = v; instr = ins; addr_lo = o; reg_val = r; mem_word = m;
        p_valid = v; p_ins = ins; p_off = o; p_reg = r; p_mem = m; p_hasx = hx; p_x = x;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] lr_x [4];
        logic [31:0] ll_x [4];
        logic [31:0] sr_m [4];
        logic [31:0] sr_x [4];
        logic [31:0] sl_m [4];
        logic [31:0] sl_x [4];
        lr_x = '{32'hAABBCC01, 32'hAABB0102, 32'hAA010203, 32'h01020304};
        ll_x = '{32'h01020304, 32'h020304DD, 32'h0304CCDD, 32'h04BBCCDD};
        sr_m = '{32'h01020304, 32'h05060708, 32'h090A0B0C, 32'h0D0E0F00};
        sr_x = '{32'hDD020304, 32'hCCDD0708, 32'hBBCCDD0C, 32'hAABBCCDD};
        sl_m = '{32'h11121314, 32'h191A1B1C, 32'h1D1E1F10, 32'h21222324};
        sl_x = '{32'hAABBCCDD, 32'h19AABBCC, 32'h1D1EAABB, 32'h212223AA};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs cleared by reset
        chk(out_valid === 1'b0 && load_data === '0 && store_data === '0 && store_be === '0,
            "R1", load_data, 32'h0);

        // directed big-endian vectors (R4..R8, R10)
        for (int o = 0; o < 4; o++) step(1'b1, 6'h26, 2'(o), 32'hAABBCCDD, 32'h01020304, 1'b1, lr_x[o]);
        for (int o = 0; o < 4; o++) step(1'b1, 6'h22, 2'(o), 32'hAABBCCDD, 32'h01020304, 1'b1, ll_x[o]);
        step(1'b0, 6'h00, 2'd0, 32'h0, 32'h0, 1'b0, 32'h0);
        for (int o = 0; o < 4; o++) step(1'b1, 6'h2E, 2'(o), 32'hAABBCCDD, sr_m[o], 1'b1, sr_x[o]);
        for (int o = 0; o < 4; o++) step(1'b1, 6'h2A, 2'(o), 32'hAABBCCDD, sl_m[o], 1'b1, sl_x[o]);

        // R3/R9: neighbouring opcodes stay plain
        step(1'b1, 6'h23, 2'd1, 32'h12345678, 32'hCAFEF00D, 1'b0, 32'h0);
        step(1'b1, 6'h2B, 2'd2, 32'h0BADBEEF, 32'h55AA55AA, 1'b0, 32'h0);
        step(1'b1, 6'h20, 2'd3, 32'hFEEDFACE, 32'h01234567, 1'b0, 32'h0);

        // R11: idle cycles hold the outputs
        repeat (3) step(1'b0, 6'h22, 2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 32'h0);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [5:0] op;
            case ($urandom_range(0, 4))
                0: op = 6'h22;
                1: op = 6'h26;
                2: op = 6'h2A;
                3: op = 6'h2E;
                default: op = 6'($urandom);
            endcase
            step(($urandom_range(0, 3) != 0), op, 2'($urandom), $urandom, $urandom, 1'b0, 32'h0);
        end
        step(1'b0, 6'h00, 2'd0, 32'h0, 32'h0, 1'b0, 32'h0);
        step(1'b0, 6'h00, 2'd0, 32'h0, 32'h0, 1'b0, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule